// File: doc/BRIEF.md
# Scaled-Increment System Time Counter

This block keeps the running time of a precision-time hardware clock as a 64-bit count whose unit is a binary fraction of a nanosecond. An internal tick divider counts clock cycles. Each time it reaches a programmed period, it adds a programmed 24-bit increment to the count. With the reset setting, the block adds `16 << 19` on every cycle of a 16 ns clock. The count unit is then 2^-19 ns: the low 19 bits hold fractional nanoseconds, and the 45 bits above them hold whole nanoseconds, which wrap after roughly 9.77 hours.

Software reaches the block through a simple word-wide register port. Reading the low time word also captures the high word, so the high word read that follows belongs to the same instant. Writing the low time word only stages it. Writing the high word then loads both halves into the count on one edge. To trim the frequency, software rewrites the increment register with the nominal increment raised or lowered by a small delta. Writing the increment register restarts the tick divider.

Top module: `systime_ctr`

## Requirements
- R1: After reset the count is zero, the captured high word reads zero, and the increment register reads 0x0180_0000 (period 1, increment 0x80_0000).
- R2: The increment register sits at address 2. Bits 31:24 are the tick period and bits 23:0 are the increment value. A read returns the last value written.
- R3: With period p >= 1, after an increment-register write at edge E, the increment is added at edges E+p, E+2p, and so on. The count changes at no other edge except a load.
- R4: A period field of zero holds the count at its value until a load.
- R5: A write to the increment register restarts the tick divider and suppresses any addition at that edge.
- R6: The count wraps modulo 2^64.
- R7: Reading address 0 returns bits 31:0 of the live count and captures bits 63:32. Reading address 1 returns the captured word.
- R8: Writing address 0 only stages a low word and leaves the count unchanged. Writing address 1 loads {written word, staged word} into the count on that edge, in place of any addition. Address 3 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 low time, 1 high time, 2 increment |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |

## Verification
On every cycle, the assertions check the following properties:
- the count either holds or grows by exactly the increment in force, apart from loads;
- a zero period freezes the count;
- the tick divider stays below the period;
- a low read captures the high word;
- a high write loads the count;
- an increment write lands in the register.

Only the bench's scenarios show the following behaviours:
- the exact number of additions over a window for a given period;
- the restart of the divider on a rewrite;
- wrap-around of the full count;
- the coherence of a split read while the counter runs.

// File: rtl/systime_pkg.sv
package systime_pkg;
    parameter int CNT_W  = 64;
    parameter int WORD_W = 32;
    parameter int PER_W  = 8;
    parameter int INC_W  = 24;
    parameter int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_TLO = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_THI = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_INC = 2'd2;

    localparam logic [PER_W-1:0] NOM_PERIOD = 8'd1;
    localparam logic [INC_W-1:0] NOM_STEP   = INC_W'(16) << 19;

    typedef struct packed {
        logic [WORD_W-1:0] incr;
        logic [WORD_W-1:0] lo_stage;
        logic [WORD_W-1:0] hi_snap;
    } regs_t;
endpackage

// File: rtl/systime_tick_div.sv
module systime_tick_div #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    input  logic             restart,
    output logic             step,
    output logic [PER_W-1:0] tick_cnt
);
    logic [PER_W-1:0] cnt_d, cnt_q;
    logic             hit;

    always_comb begin
        hit   = (period != '0) && (cnt_q == period - PER_W'(1));
        cnt_d = cnt_q + PER_W'(1);
        if (restart || period == '0 || hit)
            cnt_d = '0;
        step = hit && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_cnt = cnt_q;
endmodule

// File: rtl/systime_accum.sv
module systime_accum #(
    parameter int CNT_W = 64,
    parameter int INC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [INC_W-1:0] inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load)
            count_d = load_val;
        else if (step)
            count_d = count_q + CNT_W'(inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/systime_ctr.sv
module systime_ctr
    import systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam int INC_LSB = 0;
    localparam int PER_LSB = INC_W;

    regs_t            r_d, r_q;
    logic [CNT_W-1:0] count_q;
    logic [PER_W-1:0] tick_q;
    logic             step;
    logic             wr_lo, wr_hi, wr_inc, rd_lo;

    always_comb begin
        wr_lo  = reg_wr && reg_addr == ADR_TLO;
        wr_hi  = reg_wr && reg_addr == ADR_THI;
        wr_inc = reg_wr && reg_addr == ADR_INC;
        rd_lo  = reg_rd && reg_addr == ADR_TLO;

        r_d = r_q;
        if (wr_lo)  r_d.lo_stage = reg_wdata;
        if (wr_inc) r_d.incr     = reg_wdata;
        if (rd_lo)  r_d.hi_snap  = count_q[CNT_W-1:WORD_W];

        case (reg_addr)
            ADR_TLO: reg_rdata = count_q[WORD_W-1:0];
            ADR_THI: reg_rdata = r_q.hi_snap;
            ADR_INC: reg_rdata = r_q.incr;
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.incr     <= {NOM_PERIOD, NOM_STEP};
            r_q.lo_stage <= '0;
            r_q.hi_snap  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    systime_tick_div #(.PER_W(PER_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .period   (r_q.incr[PER_LSB +: PER_W]),
        .restart  (wr_inc),
        .step     (step),
        .tick_cnt (tick_q)
    );

    systime_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .inc      (r_q.incr[INC_LSB +: INC_W]),
        .load     (wr_hi),
        .load_val ({reg_wdata, r_q.lo_stage}),
        .count    (count_q)
    );
endmodule

// File: rtl/systime_ctr_chk.sv
module systime_ctr_chk
    import systime_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] incr,
    input logic [WORD_W-1:0] snap,
    input logic [CNT_W-1:0]  count,
    input logic [PER_W-1:0]  tick
);
    logic load;
    assign load = reg_wr && reg_addr == ADR_THI;

    assert_inc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_INC) |=> incr == $past(reg_wdata));

    assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (count == $past(count)) ||
                  (count == $past(count) + CNT_W'($past(incr[INC_W-1:0]))));

    assert_tick_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (incr[WORD_W-1:INC_W] != '0) |-> tick < incr[WORD_W-1:INC_W]);

    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (incr[WORD_W-1:INC_W] == '0 && !load) |=> $stable(count));

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_INC) |=> (tick == '0 && count == $past(count)));

    assert_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADR_TLO) |=> snap == $past(count[CNT_W-1:WORD_W]));

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count[CNT_W-1:WORD_W] == $past(reg_wdata));
endmodule

bind systime_ctr systime_ctr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .incr      (r_q.incr),
    .snap      (r_q.hi_snap),
    .count     (count_q),
    .tick      (tick_q)
);

// File: tb/systime_ctr_bench.sv
`timescale 1ns/1ps
module systime_ctr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    systime_ctr u_systime_ctr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [7:0]  per;
        logic [23:0] inc;
        logic [63:0] start;
        logic [15:0] idle;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'd1,   24'h800000, 64'h0,                  16'd10},
        '{8'd3,   24'h800000, 64'h100,                16'd10},
        '{8'd1,   24'h801234, 64'h0,                  16'd4},
        '{8'd1,   24'h7FEDCC, 64'h0,                  16'd4},
        '{8'd0,   24'h800000, 64'hABCD,               16'd20},
        '{8'd1,   24'hFFFFFF, 64'hFFFF_FFFF_FF00_0000, 16'd2},
        '{8'd255, 24'h000010, 64'h5,                  16'd300},
        '{8'd2,   24'h800000, 64'h5_FFFF_FF00,        16'd4}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd64(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic set_count(input logic [63:0] v);
        wr(2'd2, 32'h0000_0000);
        wr(2'd0, v[31:0]);
        wr(2'd1, v[63:32]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [63:0] v, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd2, w); check("R1 incr reset", 64'(w), 64'h0180_0000);
        rd(2'd1, w); check("R1 snapshot reset", 64'(w), 64'h0);
        wr(2'd2, 32'h0);
        rd64(v);     check("R1 count near zero after reset", 64'(v < 64'h1000_0000), 64'h1);

        // R3 R4 R6: vector table
        for (int i = 0; i < NV; i++) begin
            set_count(VEC[i].start);
            wr(2'd2, {VEC[i].per, VEC[i].inc});
            repeat (int'(VEC[i].idle)) @(negedge clk);
            wr(2'd2, 32'h0);
            rd64(v);
            exp = VEC[i].start;
            if (VEC[i].per != 0)
                exp = exp + 64'(VEC[i].idle / VEC[i].per) * 64'(VEC[i].inc);
            check($sformatf("R3 R4 R6 vector %0d", i), v, exp);
        end

        // R2: increment register layout and readback
        wr(2'd2, 32'h0380_1234);
        rd(2'd2, w); check("R2 incr readback", 64'(w), 64'h0380_1234);
        wr(2'd2, 32'h0);

        // R5: rewrite restarts the divider
        set_count(64'h0);
        wr(2'd2, 32'h0400_0010);
        repeat (2) @(negedge clk);
        wr(2'd2, 32'h0400_0010);
        repeat (3) @(negedge clk);
        wr(2'd2, 32'h0);
        rd64(v); check("R5 restart on rewrite", v, 64'h0);

        // R8: low write only stages
        set_count(64'h1111_2222_3333_4444);
        wr(2'd0, 32'hDEAD_BEEF);
        rd(2'd0, w); check("R8 low write staged only", 64'(w), 64'h3333_4444);
        wr(2'd1, 32'h0000_0042);
        rd64(v); check("R8 commit uses staged low", v, 64'h42_DEAD_BEEF);

        // R8: load overrides addition while running
        wr(2'd2, 32'h0180_0000);
        wr(2'd0, 32'h0000_1234);
        wr(2'd1, 32'h0000_0077);
        wr(2'd2, 32'h0);
        rd64(v); check("R8 load while running", v, 64'h77_0000_1234);

        // R8: address 3 ignored, reads zero
        wr(2'd3, 32'hFFFF_FFFF);
        rd64(v); check("R8 addr3 write ignored", v, 64'h77_0000_1234);
        rd(2'd3, w); check("R8 addr3 reads zero", 64'(w), 64'h0);

        // R7: coherent split read while running
        set_count(64'h5_FFFF_F000);
        wr(2'd2, 32'h0180_0000);
        rd(2'd0, w); check("R7 low read live", 64'(w), 64'hFFFF_F000);
        repeat (4) @(negedge clk);
        rd(2'd1, w); check("R7 high from capture", 64'(w), 64'h5);
        wr(2'd2, 32'h0);
        rd64(v); check("R7 count moved on", 64'(v[63:32]), 64'h6);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule